// File: doc/BRIEF.md
# Per-Channel Output Source and Driver Enable

This block sits between the connection memories and the serial output shifter of a time-slot switch. For each output stream and channel it is loaded with that location's three control bits and its connection byte, one channel period ahead of transmission. From these it decides two things. The first is whether the channel carries a switched byte taken from data memory or a fixed message byte held in the connection byte. The second is whether the channel's tri-state driver is on.

In switched mode the connection byte names a source stream and a source channel. The block presents that address to data memory and captures the byte that comes back. In message mode the connection byte itself is the payload.

A global message switch forces every channel into message mode with its driver on. An external drive-enable pin turns every driver off at once.

The selected byte, the control-stream bit and the per-channel enable are held in registers until the next load. The serialiser therefore sees values that do not change during the channel.

Top module: `chan_out_ctl`

## Requirements
- R1: After reset, byte_o, cst_o, drive_en_o and rd_req_o are all 0.
- R2: When cmh_i bit 2 (message flag) is 1 at a load, byte_o equals the loaded cml_i byte from the second rising edge after the load.
- R3: When the effective message flag is 0, rd_req_o is 1 in the cycle after the load. In that cycle rd_stream_o equals cml_i[7:5] and rd_chan_o equals cml_i[4:0]. byte_o then takes the dm_data_i value returned in that cycle, at the next edge.
- R4: When msg_en_i is 1 at a load, the channel behaves as if cmh_i bits 2 and 0 were both 1, whatever their actual values.
- R5: While ode_i is 0, drive_en_o is 0 in the same cycle, whatever was loaded.
- R6: While ode_i is 1, drive_en_o equals the effective output enable (cmh_i bit 0 OR msg_en_i) of the last load.
- R7: cst_o equals cmh_i bit 1 of the last load from the second edge after it, and msg_en_i has no effect on it.
- R8: Without a load, byte_o, cst_o and the registered enable hold their values even when the other inputs change.
- R9: rd_req_o stays 0 in the cycle after a load whose effective message flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load strobe for one channel location |
| cmh_i | input | 3 | Control bits: [2] message flag, [1] control-stream bit, [0] output enable |
| cml_i | input | 8 | Connection byte: message payload, or source stream [7:5] and source channel [4:0] |
| msg_en_i | input | 1 | Global message-mode force |
| ode_i | input | 1 | External output-drive enable, active high |
| dm_data_i | input | 8 | Data-memory byte returned for the address on rd_stream_o/rd_chan_o |
| rd_req_o | output | 1 | Data-memory read request |
| rd_stream_o | output | 3 | Source stream address to data memory |
| rd_chan_o | output | 5 | Source channel address to data memory |
| byte_o | output | 8 | Byte to serialise for the channel |
| cst_o | output | 1 | Control-stream bit for the channel |
| drive_en_o | output | 1 | Tri-state driver enable for the channel |

## Verification
All sixteen combinations of ode_i, msg_en_i, message flag and output enable are applied. Each loads a distinct connection byte, and each is compared with a reference function. This separates the forcing by the global switch from the stored bits, and separates the pin override from the per-channel enable. The data-memory model returns a byte that differs from the address. A switched channel that wrongly emits the connection byte therefore shows as a mismatch, and so does a message channel that wrongly emits the memory byte. Further directed cases cover three things: control-stream pass-through with and without the global force, holding between loads, and the pin dropping while an enabled channel is held.

// File: rtl/chan_ctl_pkg.sv
package chan_ctl_pkg;
  localparam int STREAM_W = 3;
  localparam int CHAN_W   = 5;
  localparam int DATA_W   = STREAM_W + CHAN_W;

  typedef struct packed {
    logic msg;  // bit 2
    logic cst;  // bit 1
    logic oe;   // bit 0
  } cmh_t;
endpackage

// File: rtl/chan_ctl_stage.sv
module chan_ctl_stage
  import chan_ctl_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  cmh_t          cmh_i,
  input  logic [DW-1:0] cml_i,
  input  logic          msg_en_i,
  output logic          vld_o,
  output cmh_t          eff_o,
  output logic [DW-1:0] cml_o
);
  cmh_t eff_d;

  // global force sets msg and oe, leaves cst alone
  always_comb begin
    eff_d     = cmh_i;
    eff_d.msg = cmh_i.msg | msg_en_i;
    eff_d.oe  = cmh_i.oe  | msg_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      eff_o <= '0;
      cml_o <= '0;
    end else begin
      vld_o <= load_i;
      if (load_i) begin
        eff_o <= eff_d;
        cml_o <= cml_i;
      end
    end
  end

  // R4
  force_msg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && msg_en_i |=> eff_o.msg && eff_o.oe);
endmodule

// File: rtl/chan_ctl_sel.sv
module chan_ctl_sel
  import chan_ctl_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  cmh_t          eff_i,
  input  logic [DW-1:0] cml_i,
  input  logic [DW-1:0] dm_data_i,
  output logic [DW-1:0] data_o,
  output logic          cst_o,
  output logic          en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      cst_o  <= 1'b0;
      en_o   <= 1'b0;
    end else if (vld_i) begin
      data_o <= eff_i.msg ? cml_i : dm_data_i;
      cst_o  <= eff_i.cst;
      en_o   <= eff_i.oe;
    end
  end

  // R2
  msg_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && eff_i.msg |=> data_o == $past(cml_i));
  // R3
  sw_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && !eff_i.msg |=> data_o == $past(dm_data_i));
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(data_o) && $stable(cst_o) && $stable(en_o));
endmodule

// File: rtl/chan_out_ctl.sv
module chan_out_ctl
  import chan_ctl_pkg::*;
#(
  parameter int SW = STREAM_W,
  parameter int CW = CHAN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [2:0]       cmh_i,
  input  logic [SW+CW-1:0] cml_i,
  input  logic             msg_en_i,
  input  logic             ode_i,
  input  logic [SW+CW-1:0] dm_data_i,
  output logic             rd_req_o,
  output logic [SW-1:0]    rd_stream_o,
  output logic [CW-1:0]    rd_chan_o,
  output logic [SW+CW-1:0] byte_o,
  output logic             cst_o,
  output logic             drive_en_o
);
  localparam int DW = SW + CW;

  cmh_t          cmh_in;
  logic          s1_vld;
  cmh_t          s1_eff;
  logic [DW-1:0] s1_cml;
  logic          en_q;

  assign cmh_in = cmh_t'(cmh_i);

  chan_ctl_stage #(.DW(DW)) u_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .cmh_i    (cmh_in),
    .cml_i    (cml_i),
    .msg_en_i (msg_en_i),
    .vld_o    (s1_vld),
    .eff_o    (s1_eff),
    .cml_o    (s1_cml)
  );

  assign rd_req_o    = s1_vld & ~s1_eff.msg;
  assign rd_stream_o = s1_cml[DW-1:CW];
  assign rd_chan_o   = s1_cml[CW-1:0];

  chan_ctl_sel #(.DW(DW)) u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (s1_vld),
    .eff_i     (s1_eff),
    .cml_i     (s1_cml),
    .dm_data_i (dm_data_i),
    .data_o    (byte_o),
    .cst_o     (cst_o),
    .en_o      (en_q)
  );

  // pin acts without a register so it can kill drivers at once
  assign drive_en_o = en_q & ode_i;

  // R9
  no_read_msg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && (cmh_i[2] || msg_en_i) |=> !rd_req_o);
  // R4
  force_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && msg_en_i |=> ##1 en_q);
  // R7
  cst_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ##1 cst_o == $past(cmh_i[1], 2));
endmodule

// File: tb/chan_out_ctl_test.sv
module chan_out_ctl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [2:0] cmh = '0;
  logic [7:0] cml = '0;
  logic       me = 1'b0;
  logic       ode = 1'b0;
  logic [7:0] dm;
  logic       rd_req;
  logic [2:0] rd_st;
  logic [4:0] rd_ch;
  logic [7:0] byte_q;
  logic       cst, den;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // data-memory model: byte differs from its address
  assign dm = {rd_st, rd_ch} ^ 8'hA5;

  chan_out_ctl uut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .cmh_i(cmh), .cml_i(cml),
    .msg_en_i(me), .ode_i(ode), .dm_data_i(dm), .rd_req_o(rd_req),
    .rd_stream_o(rd_st), .rd_chan_o(rd_ch), .byte_o(byte_q), .cst_o(cst),
    .drive_en_o(den)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // load one location, check read phase, then outputs
  task automatic load_chan(input logic pin, input logic m, input logic [2:0] c,
                           input logic [7:0] l);
    logic eff_msg, eff_oe;
    eff_msg = c[2] | m;
    eff_oe  = c[0] | m;
    @(negedge clk);
    load = 1'b1; cmh = c; cml = l; me = m; ode = pin;
    @(negedge clk);
    load = 1'b0;
    chk("R9/R3 rd_req", rd_req, !eff_msg);
    if (!eff_msg) begin
      chk("R3 rd_stream", rd_st, l[7:5]);
      chk("R3 rd_chan", rd_ch, l[4:0]);
    end
    @(negedge clk);
    chk(eff_msg ? "R2/R4 byte" : "R3 byte", byte_q, eff_msg ? l : (l ^ 8'hA5));
    chk(pin ? "R6 drive_en" : "R5 drive_en", den, pin & eff_oe);
    chk("R7 cst", cst, c[1]);
  endtask

  task automatic t_reset();
    chk("R1 byte", byte_q, 0);
    chk("R1 cst", cst, 0);
    chk("R1 drive_en", den, 0);
    chk("R1 rd_req", rd_req, 0);
  endtask

  task automatic t_combos();
    for (int i = 0; i < 16; i++) begin
      logic [2:0] c;
      c = {i[1], i[0] ^ i[1], i[0]};
      load_chan(i[3], i[2], c, 8'(8'h13 + i * 8'h29));
    end
  endtask

  task automatic t_cst();
    load_chan(1'b1, 1'b1, 3'b010, 8'h3C);
    load_chan(1'b1, 1'b1, 3'b000, 8'hC3);
    load_chan(1'b1, 1'b0, 3'b010, 8'h7E);
  endtask

  task automatic t_hold();
    load_chan(1'b1, 1'b0, 3'b111, 8'h5A);
    @(negedge clk);
    cmh = 3'b000; cml = 8'hFF; me = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 byte hold", byte_q, 8'h5A);
    chk("R8 cst hold", cst, 1);
    chk("R8 en hold", den, 1);
  endtask

  task automatic t_pin_drop();
    load_chan(1'b1, 1'b0, 3'b001, 8'h21);
    ode = 1'b0;
    #1;
    chk("R5 pin drop", den, 0);
    @(negedge clk);
    ode = 1'b1;
    #1;
    chk("R6 pin restore", den, 1);
  endtask

  initial begin
    #2000000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_combos();
    t_cst();
    t_hold();
    t_pin_drop();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule